// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects level interrupt requests from a set of protection controllers and bus bridges into three software-visible registers. The first is a live status word. The second is a write-only clear word. The third is an enable word. The block drives one combined level interrupt, which is high while any enabled source is asserting. Software reads the status word to find which unit raised the request. It then writes a 1 to the matching clear bit. That write sends a one-cycle pulse back to the originating unit, and the unit drops its request.

Two bit layouts can be chosen by parameter.

- **Wide layout:** internal sources sit in the low half-word and up to sixteen expansion sources sit in bits [31:16].
- **Peripheral-controller layout:** expansion AHB sources sit at [23:20], expansion APB sources at [7:4], and two internal sources at bits 1 and 0.

An expansion-disable mask and an internal-source mask decide which bit positions exist. A missing position reads zero, holds no enable flop and never pulses a clear.

Top module: `isa_agg`

## Requirements
- R1: The status word (address 0) is the current level of `src_level` at every implemented bit position, combinationally, with no latching.
- R2: A bit position that is not implemented (internal-source mask bit 0, or expansion-disable bit 1) reads 0 in status and never contributes to `irq`.
- R3: A write to address 1 drives `clr_pulse` with the written data ANDed with the implemented-bit mask. The pulse is high during the clock cycle that follows the write edge. Bits written 0 stay low.
- R4: `clr_pulse` lasts exactly one cycle, and it is all-zero in any cycle not preceded by a clear write.
- R5: Writes to non-implemented clear bits produce no pulse.
- R6: A write to address 2 stores the written data masked by the implemented bits into the enable word. Reads of address 2 return that word. Writes to addresses 0, 1 and 3 leave the enable word unchanged.
- R7: `irq` is high exactly when some bit is set in both status and enable. It follows the source level combinationally, so it falls in the same cycle as the source.
- R8: Synchronous active-high reset clears the enable word and `clr_pulse`.
- R9: Reads of the clear register (address 1) and of the reserved address 3 return zero.
- R10: With the peripheral-controller layout, the live bits are:
  - [23:20] for expansion AHB sources, where expansion-disable bit i (i < 4) removes bit 20+i;
  - [7:4] for expansion APB sources, where disable bit 4+j removes bit 4+j;
  - bits 1 and 0 for internal sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 32 | Source interrupt levels, placed at register bit positions |
| wr_en | input | 1 | Register write strobe (full 32-bit word) |
| wr_addr | input | 2 | Write address: 0 status, 1 clear, 2 enable, 3 reserved |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same encoding |
| rd_data | output | 32 | Read data, combinational |
| clr_pulse | output | 32 | Per-source clear pulses back to the originating units |
| irq | output | 1 | Combined level interrupt |

## Verification
Two kinds of source pattern are applied:

- **Walking single-bit patterns** show whether every bit position maps straight through or is masked off by the implementation parameters.
- **The all-ones pattern** catches a wrong disable mask in a single read.

The interrupt is then checked under three enable conditions: a full enable word, a single internal bit enabled, and a source that rises on a masked or disabled bit. Together these separate a missing mask from a missing OR and from a latched status.

The clear path is fed four kinds of write: all-ones, a sparse pattern, zero, and writes to the other addresses. A scoreboard compares `clr_pulse` every cycle, so a stretched, missing or stray pulse is caught. A second instance built with the peripheral-controller layout confirms that the alternative bit placement is the one in use.

// File: rtl/isa_pkg.sv
package isa_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned EXP_N = 16;

    localparam int LAY_WIDE = 0;
    localparam int LAY_PPC  = 1;

    typedef enum logic [1:0] {
        A_STAT = 2'd0,
        A_CLR  = 2'd1,
        A_EN   = 2'd2,
        A_RSVD = 2'd3
    } isa_addr_e;

    typedef struct packed {
        logic             en;
        isa_addr_e        addr;
        logic [REG_W-1:0] data;
    } isa_wr_t;

    // Which register bit positions carry a real source.
    function automatic logic [REG_W-1:0] live_mask(input int lay,
                                                   input logic [15:0] int_src,
                                                   input logic [EXP_N-1:0] exp_dis);
        logic [REG_W-1:0] m;
        m = '0;
        if (lay == LAY_PPC) begin
            m[1:0]   = int_src[1:0];
            m[7:4]   = ~exp_dis[7:4];
            m[23:20] = ~exp_dis[3:0];
        end else begin
            m[15:0]  = int_src;
            m[31:16] = ~exp_dis;
        end
        return m;
    endfunction

endpackage

// File: rtl/isa_en_bank.sv
module isa_en_bank
    import isa_pkg::*;
#(
    parameter logic [REG_W-1:0] LIVE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  isa_wr_t          wr,
    output logic [REG_W-1:0] en_q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (LIVE[i]) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    en_q[i] <= 1'b0;
                else if (wr.en && wr.addr == A_EN)
                    en_q[i] <= wr.data[i];
            end
        end else begin : g_tie
            assign en_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isa_clr_pulse.sv
module isa_clr_pulse
    import isa_pkg::*;
#(
    parameter logic [REG_W-1:0] LIVE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  isa_wr_t          wr,
    output logic [REG_W-1:0] pulse_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= '0;
        else if (wr.en && wr.addr == A_CLR)
            pulse_q <= wr.data & LIVE;
        else
            pulse_q <= '0;
    end
endmodule

// File: rtl/isa_rd_mux.sv
module isa_rd_mux
    import isa_pkg::*;
(
    input  isa_addr_e        addr,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] enable,
    output logic [REG_W-1:0] data
);
    always_comb begin
        unique case (addr)
            A_STAT:  data = status;
            A_EN:    data = enable;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/isa_agg.sv
module isa_agg
    import isa_pkg::*;
#(
    parameter int               LAYOUT  = LAY_WIDE,
    parameter logic [15:0]      INT_SRC = 16'h0001,
    parameter logic [EXP_N-1:0] EXP_DIS = 16'h0F00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src_level,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] clr_pulse,
    output logic             irq
);
    localparam logic [REG_W-1:0] LIVE = live_mask(LAYOUT, INT_SRC, EXP_DIS);

    isa_wr_t          wr;
    logic [REG_W-1:0] status_w;
    logic [REG_W-1:0] en_q;

    assign wr.en   = wr_en;
    assign wr.addr = isa_addr_e'(wr_addr);
    assign wr.data = wr_data;

    assign status_w = src_level & LIVE;

    isa_en_bank #(.LIVE(LIVE)) u_en (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .en_q (en_q)
    );

    isa_clr_pulse #(.LIVE(LIVE)) u_clr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .pulse_q (clr_pulse)
    );

    isa_rd_mux u_rd (
        .addr   (isa_addr_e'(rd_addr)),
        .status (status_w),
        .enable (en_q),
        .data   (rd_data)
    );

    assign irq = |(status_w & en_q);
endmodule

// File: rtl/isa_agg_chk.sv
module isa_agg_chk #(
    parameter logic [31:0] LIVE = '1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] src_level,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [1:0]  rd_addr,
    input logic [31:0] rd_data,
    input logic [31:0] clr_pulse,
    input logic        irq,
    input logic [31:0] en_q
);
    // R3
    clr_match_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> (clr_pulse == ($past(wr_data) & LIVE)));

    // R4
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == 2'd1) |=> (clr_pulse == 32'h0));

    // R2
    stat_dead_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd0) |-> ((rd_data & ~LIVE) == 32'h0));

    // R9
    clr_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd1 || rd_addr == 2'd3) |-> (rd_data == 32'h0));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((src_level & en_q) == 32'h0) |-> !irq);

    // R6
    en_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=> (en_q == ($past(wr_data) & LIVE)));

    // R8
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == 32'h0 && clr_pulse == 32'h0));
endmodule

bind isa_agg isa_agg_chk #(.LIVE(LIVE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_level (src_level),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .clr_pulse (clr_pulse),
    .irq       (irq),
    .en_q      (en_q)
);

// File: tb/isa_agg_bench.sv
`timescale 1ns/1ps
module isa_agg_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic [31:0] src, src2, wr_data;
    logic        wr_en;
    logic [1:0]  wr_addr, rd_addr;
    logic [31:0] rd_data, rd2, clr, clr2;
    logic        irq, irq2;

    // Expected live masks, from R2 and R10.
    localparam logic [31:0] M1 = 32'hF0FF_0001;
    localparam logic [31:0] M2 = 32'h00F0_00D3;

    int checks = 0;
    int errors = 0;
    logic [31:0] expq[$];

    isa_agg #(.LAYOUT(0), .INT_SRC(16'h0001), .EXP_DIS(16'h0F00)) u_isa_agg (
        .clk(clk), .rst(rst), .src_level(src), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .clr_pulse(clr), .irq(irq));

    isa_agg #(.LAYOUT(1), .INT_SRC(16'h0003), .EXP_DIS(16'h0020)) u_isa_agg_ppc (
        .clk(clk), .rst(rst), .src_level(src2), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd2),
        .clr_pulse(clr2), .irq(irq2));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of bus activity, expected clear pulse queued.
    task automatic cyc(input logic e, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = e; wr_addr = a; wr_data = d;
        expq.push_back((e && a == 2'd1 && !rst) ? (d & M1) : 32'h0);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 2'd0, 32'h0);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic irqchk(input logic exp, input string tag);
        cyc(1'b0, 2'd0, 32'h0);
        #1;
        chk(tag, {31'h0, irq}, {31'h0, exp});
    endtask

    // Monitor: compares clr_pulse against the scoreboard each cycle (R3 R4 R5).
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0)
            chk("R3 R4 R5 clear pulse", clr, expq.pop_front());
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'h0;
        rd_addr = 2'd0; src = 32'h0; src2 = 32'h0;
        repeat (3) cyc(1'b0, 2'd0, 32'h0);
        rst = 1'b0;

        rd(2'd2, 32'h0, "R8 enable after reset");
        irqchk(1'b0, "R8 irq after reset");

        src = 32'hFFFF_FFFF;
        rd(2'd0, M1, "R1 R2 status all ones");
        irqchk(1'b0, "R7 all masked");

        for (int i = 0; i < 32; i++) begin
            src = 32'h1 << i;
            rd(2'd0, (32'h1 << i) & M1, "R1 walking status");
        end

        cyc(1'b1, 2'd2, 32'hFFFF_FFFF);
        rd(2'd2, M1, "R6 enable store");
        src = 32'h0001_0000;
        irqchk(1'b1, "R7 expansion source");
        src = 32'h0100_0000;
        irqchk(1'b0, "R2 disabled source");

        cyc(1'b1, 2'd2, 32'h0000_0001);
        src = 32'h0001_0000;
        irqchk(1'b0, "R7 masked source");
        src = 32'h0000_0001;
        irqchk(1'b1, "R7 internal source");
        src = 32'h0;
        irqchk(1'b0, "R7 level fall");

        cyc(1'b1, 2'd1, 32'hFFFF_FFFF);
        cyc(1'b1, 2'd1, 32'h0005_0000);
        cyc(1'b0, 2'd0, 32'h0);
        cyc(1'b1, 2'd1, 32'h0);
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF);
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0, "R9 reserved reads zero");
        rd(2'd1, 32'h0, "R9 clear reads zero");
        rd(2'd2, 32'h1, "R6 enable kept by other writes");

        // Peripheral-controller layout instance.
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF);
        rd(2'd2, M1, "R6 enable store again");
        chk("R10 layout enable", rd2, M2);
        src2 = 32'hFFFF_FFFF;
        rd(2'd0, 32'h0, "R1 status quiet");
        chk("R10 layout status", rd2, M2);
        chk("R10 layout irq", {31'h0, irq2}, 32'h1);
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        chk("R10 layout clear pulse", clr2, M2);

        rst = 1'b1;
        cyc(1'b0, 2'd0, 32'h0);
        cyc(1'b0, 2'd0, 32'h0);
        rst = 1'b0;
        rd(2'd2, 32'h0, "R8 enable after mid reset");
        chk("R8 layout enable after reset", rd2, 32'h0);

        @(posedge clk); #2;
        finish_run();
    end
endmodule